// File: doc/BRIEF.md
# Debug Bus Access Control Word

This block is the control and status word that a debug access port uses to steer the system-bus master behind it. A debugger writes the word over a simple strobed register interface and reads it back at any time. The writable settings are the master identity, the user/privileged protection attribute and the operating mode for the bus transfers that follow. The word also reports two live conditions: whether the bus master is still busy with a transfer, and whether the debug-enable input currently allows bus access.

The identity field cannot change while a transfer is outstanding, so that a transfer in flight never sees its master identity switch. A strap input can pin the identity output to "debugger" regardless of the stored bit. While debug access is disabled, transfer requests from the port are dropped and never reach the bus master. The bus master, its address stepping and its size logic sit outside this block; only the busy indication comes back from it.

Top module: `dbg_csw_ctrl`

## Requirements
- R1: After synchronous reset, with busy and debug-enable both low, the read word is 0x2300_0000: identity bit 29 = 1, protection bit 25 = 1, bit 24 = 1, mode bits 11:8 = 0000.
- R2: With busy low, a write updates the identity bit 29 on the clock edge that samples the write strobe; the new value is visible on the read word and on `master_type_o` (0 = core, 1 = debugger) after that edge.
- R3: A write sampled while `xfer_busy_i` is high leaves identity bit 29 unchanged, while the protection bit in the same write still updates.
- R4: While `fix_mtype_i` is 1, `master_type_o` is 1 whatever bit 29 holds; bit 29 itself still reads back the stored value.
- R5: Bit 25 is writable and `hprot1_o` always equals it.
- R6: Mode bits 11:8 accept only 0000; a write carrying any other value (0001 to 1111) leaves the field at 0000.
- R7: Bit 7 is read-only and equals `xfer_busy_i` in the same cycle.
- R8: Bit 6 is read-only and equals `dbg_enable_i` in the same cycle; `xfer_permit_o` equals `dbg_enable_i`.
- R9: Bits 31:30, 28:26 and 23:12 always read 0 and bit 24 always reads 1; writes to them, and to bits 7 and 6, have no effect.
- R10: A `xfer_req_i` sampled high with `dbg_enable_i` high produces `bus_req_o` high for exactly the following cycle.
- R11: A `xfer_req_i` sampled while `dbg_enable_i` is low is dropped: `bus_req_o` stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Word written when the strobe is high |
| reg_rd_data | output | 32 | Current control and status word |
| xfer_busy_i | input | 1 | Bus master has a transfer outstanding |
| dbg_enable_i | input | 1 | Debug access to the bus is allowed |
| fix_mtype_i | input | 1 | Strap forcing the identity output to debugger |
| xfer_req_i | input | 1 | Port asks to start a bus transfer |
| bus_req_o | output | 1 | Registered, gated transfer start to the bus master |
| master_type_o | output | 1 | Master identity to the bus (1 = debugger) |
| hprot1_o | output | 1 | User/privileged protection attribute |
| xfer_permit_o | output | 1 | Bus transfers currently permitted |

## Verification
The checker watches, on every cycle, that an identity write during a busy cycle leaves bit 29 alone, that the strap forces the identity output, that the fixed and mode bits hold their constant values, that the two status bits track their inputs, and that no request pulse follows a disabled cycle. Whether a write lands on the right edge, whether the protection bit still updates in a write whose identity part is blocked, the exact reset word and the single-cycle width of an allowed request pulse are shown only by the bench's directed scenarios.

// File: rtl/dbg_csw_pkg.sv
package dbg_csw_pkg;

    localparam int unsigned CSW_W     = 32;
    localparam int unsigned MODE_W    = 4;
    localparam int unsigned MTYPE_BIT = 29;
    localparam int unsigned HPROT_BIT = 25;
    localparam int unsigned ONE_BIT   = 24;
    localparam int unsigned MODE_LSB  = 8;
    localparam int unsigned MODE_MSB  = MODE_LSB + MODE_W - 1;
    localparam int unsigned BUSY_BIT  = 7;
    localparam int unsigned EN_BIT    = 6;

    localparam logic [MODE_W-1:0] MODE_NORMAL = '0;

    typedef struct packed {
        logic              mtype;
        logic              hprot1;
        logic [MODE_W-1:0] mode;
    } csw_state_t;

    localparam csw_state_t CSW_RESET = '{mtype: 1'b1, hprot1: 1'b1, mode: MODE_NORMAL};

    typedef struct packed {
        logic busy;
        logic enable;
    } csw_live_t;

    function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
        return m == MODE_NORMAL;
    endfunction

    function automatic logic [CSW_W-1:0] csw_pack(input csw_state_t s, input csw_live_t l);
        logic [CSW_W-1:0] w;
        w                     = '0;
        w[MTYPE_BIT]          = s.mtype;
        w[HPROT_BIT]          = s.hprot1;
        w[ONE_BIT]            = 1'b1;
        w[MODE_MSB:MODE_LSB]  = s.mode;
        w[BUSY_BIT]           = l.busy;
        w[EN_BIT]             = l.enable;
        return w;
    endfunction

endpackage

// File: rtl/csw_field_regs.sv
module csw_field_regs
    import dbg_csw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSW_W-1:0] wr_data,
    input  logic             busy,
    output csw_state_t       state_o
);

    csw_state_t state_q;
    logic [MODE_W-1:0] mode_wr;
    logic wr_unused;

    assign mode_wr   = wr_data[MODE_MSB:MODE_LSB];
    assign wr_unused = ^{wr_data[CSW_W-1:MTYPE_BIT+1], wr_data[MTYPE_BIT-1:HPROT_BIT+1],
                         wr_data[HPROT_BIT-1:MODE_MSB+1], wr_data[MODE_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CSW_RESET;
        end else if (wr_en) begin
            if (!busy) begin
                state_q.mtype <= wr_data[MTYPE_BIT];
            end
            state_q.hprot1 <= wr_data[HPROT_BIT];
            if (mode_is_legal(mode_wr)) begin
                state_q.mode <= mode_wr;
            end
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/csw_xfer_gate.sv
module csw_xfer_gate (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic enable,
    output logic permit,
    output logic bus_req
);

    logic bus_req_q;

    assign permit = enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req_q <= 1'b0;
        end else begin
            bus_req_q <= req && enable;
        end
    end

    assign bus_req = bus_req_q;

endmodule

// File: rtl/csw_drive.sv
module csw_drive
    import dbg_csw_pkg::*;
(
    input  csw_state_t       state,
    input  csw_live_t        live,
    input  logic             fix_mtype,
    output logic [CSW_W-1:0] rd_word,
    output logic             mtype_out,
    output logic             hprot1_out
);

    always_comb begin
        rd_word    = csw_pack(state, live);
        mtype_out  = fix_mtype ? 1'b1 : state.mtype;
        hprot1_out = state.hprot1;
    end

endmodule

// File: rtl/dbg_csw_ctrl.sv
module dbg_csw_ctrl
    import dbg_csw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [CSW_W-1:0] reg_wr_data,
    output logic [CSW_W-1:0] reg_rd_data,
    input  logic             xfer_busy_i,
    input  logic             dbg_enable_i,
    input  logic             fix_mtype_i,
    input  logic             xfer_req_i,
    output logic             bus_req_o,
    output logic             master_type_o,
    output logic             hprot1_o,
    output logic             xfer_permit_o
);

    csw_state_t state;
    csw_live_t  live;

    assign live.busy   = xfer_busy_i;
    assign live.enable = dbg_enable_i;

    csw_field_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .busy    (xfer_busy_i),
        .state_o (state)
    );

    csw_drive u_drive (
        .state      (state),
        .live       (live),
        .fix_mtype  (fix_mtype_i),
        .rd_word    (reg_rd_data),
        .mtype_out  (master_type_o),
        .hprot1_out (hprot1_o)
    );

    csw_xfer_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .req     (xfer_req_i),
        .enable  (dbg_enable_i),
        .permit  (xfer_permit_o),
        .bus_req (bus_req_o)
    );

endmodule

// File: rtl/dbg_csw_checker.sv
module dbg_csw_checker
    import dbg_csw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [CSW_W-1:0] reg_rd_data,
    input logic             xfer_busy_i,
    input logic             dbg_enable_i,
    input logic             fix_mtype_i,
    input logic             bus_req_o,
    input logic             master_type_o,
    input logic             hprot1_o,
    input logic             xfer_permit_o
);

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && xfer_busy_i) |=> (reg_rd_data[MTYPE_BIT] == $past(reg_rd_data[MTYPE_BIT])));

    p_strap_force_r4: assert property (@(posedge clk) disable iff (rst)
        fix_mtype_i |-> master_type_o);

    p_hprot_out_r5: assert property (@(posedge clk) disable iff (rst)
        hprot1_o == reg_rd_data[HPROT_BIT]);

    p_mode_normal_r6: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[MODE_MSB:MODE_LSB] == MODE_NORMAL);

    p_busy_flag_r7: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[BUSY_BIT] == xfer_busy_i);

    p_enable_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[EN_BIT] == dbg_enable_i) && (xfer_permit_o == dbg_enable_i));

    p_fixed_bits_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[31:30] == 2'b00) && (reg_rd_data[28:26] == 3'b000) &&
        reg_rd_data[ONE_BIT] && (reg_rd_data[23:12] == 12'h000));

    p_req_dropped_r11: assert property (@(posedge clk) disable iff (rst)
        !dbg_enable_i |=> !bus_req_o);

endmodule

bind dbg_csw_ctrl dbg_csw_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_data   (reg_rd_data),
    .xfer_busy_i   (xfer_busy_i),
    .dbg_enable_i  (dbg_enable_i),
    .fix_mtype_i   (fix_mtype_i),
    .bus_req_o     (bus_req_o),
    .master_type_o (master_type_o),
    .hprot1_o      (hprot1_o),
    .xfer_permit_o (xfer_permit_o)
);

// File: tb/dbg_csw_ctrl_tb_top.sv
module dbg_csw_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic        xfer_busy_i;
    logic        dbg_enable_i;
    logic        fix_mtype_i;
    logic        xfer_req_i;
    logic        bus_req_o;
    logic        master_type_o;
    logic        hprot1_o;
    logic        xfer_permit_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dbg_csw_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .reg_wr_en     (reg_wr_en),
        .reg_wr_data   (reg_wr_data),
        .reg_rd_data   (reg_rd_data),
        .xfer_busy_i   (xfer_busy_i),
        .dbg_enable_i  (dbg_enable_i),
        .fix_mtype_i   (fix_mtype_i),
        .xfer_req_i    (xfer_req_i),
        .bus_req_o     (bus_req_o),
        .master_type_o (master_type_o),
        .hprot1_o      (hprot1_o),
        .xfer_permit_o (xfer_permit_o)
    );

    function automatic logic [31:0] word(input logic mt, input logic hp, input logic bz, input logic en);
        return (32'(mt) << 29) | (32'(hp) << 25) | 32'h0100_0000 | (32'(bz) << 7) | (32'(en) << 6);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        tick();
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; reg_wr_en = 0; reg_wr_data = '0; xfer_busy_i = 0;
        dbg_enable_i = 0; fix_mtype_i = 0; xfer_req_i = 0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic t_reset_r1();
        do_reset();
        check("R1 reset word", reg_rd_data, 32'h2300_0000);
        check("R1 outputs", {29'd0, master_type_o, hprot1_o, bus_req_o}, 32'd6);
    endtask

    task automatic t_mtype_write_r2();
        write_word(32'h0000_0000);
        check("R2 mtype to core", reg_rd_data, word(0, 0, 0, 0));
        check("R2 mtype out core", {31'd0, master_type_o}, 32'd0);
        write_word(32'h2000_0000);
        check("R2 mtype to debugger", {31'd0, master_type_o}, 32'd1);
    endtask

    task automatic t_busy_block_r3();
        xfer_busy_i = 1'b1;
        write_word(32'h0200_0000);
        check("R3 mtype held while busy, hprot updated", reg_rd_data, word(1, 1, 1, 0));
        write_word(32'h0000_0000);
        check("R3 held second write", reg_rd_data, word(1, 0, 1, 0));
        xfer_busy_i = 1'b0;
        write_word(32'h0000_0000);
        check("R3 applies once idle", reg_rd_data, word(0, 0, 0, 0));
    endtask

    task automatic t_strap_r4();
        fix_mtype_i = 1'b1;
        #1;
        check("R4 strap forces debugger", {31'd0, master_type_o}, 32'd1);
        check("R4 stored bit still 0", {31'd0, reg_rd_data[29]}, 32'd0);
        fix_mtype_i = 1'b0;
        #1;
        check("R4 strap released", {31'd0, master_type_o}, 32'd0);
    endtask

    task automatic t_hprot_r5();
        write_word(32'h0200_0000);
        check("R5 hprot set", {31'd0, hprot1_o}, 32'd1);
        write_word(32'h2000_0000);
        check("R5 hprot clear", {31'd0, hprot1_o}, 32'd0);
    endtask

    task automatic t_mode_r6();
        for (int m = 1; m < 16; m += 7) begin
            write_word(32'h2200_0000 | (32'(m) << 8));
            check("R6 reserved mode left 0000", reg_rd_data, word(1, 1, 0, 0));
        end
    endtask

    task automatic t_status_r7_r8();
        xfer_busy_i = 1'b1; dbg_enable_i = 1'b0;
        #1;
        check("R7 busy flag", reg_rd_data, word(1, 1, 1, 0));
        xfer_busy_i = 1'b0; dbg_enable_i = 1'b1;
        #1;
        check("R8 enable flag", reg_rd_data, word(1, 1, 0, 1));
        check("R8 permit", {31'd0, xfer_permit_o}, 32'd1);
        dbg_enable_i = 1'b0;
        #1;
        check("R8 permit low", {31'd0, xfer_permit_o}, 32'd0);
    endtask

    task automatic t_fixed_r9();
        write_word(32'hFFFF_FFFF);
        check("R9 all-ones write", reg_rd_data, word(1, 1, 0, 0));
        write_word(32'h0000_0000);
        check("R9 all-zero write", reg_rd_data, word(0, 0, 0, 0));
    endtask

    task automatic t_req_r10_r11();
        dbg_enable_i = 1'b1;
        xfer_req_i   = 1'b1;
        tick();
        xfer_req_i   = 1'b0;
        check("R10 pulse after request", {31'd0, bus_req_o}, 32'd1);
        tick();
        check("R10 pulse one cycle", {31'd0, bus_req_o}, 32'd0);
        dbg_enable_i = 1'b0;
        xfer_req_i   = 1'b1;
        tick();
        check("R11 request dropped", {31'd0, bus_req_o}, 32'd0);
        tick();
        xfer_req_i   = 1'b0;
        check("R11 still dropped", {31'd0, bus_req_o}, 32'd0);
    endtask

    initial begin
        fork
            begin
                t_reset_r1();
                t_mtype_write_r2();
                t_busy_block_r3();
                t_strap_r4();
                t_hprot_r5();
                t_mode_r6();
                t_status_r7_r8();
                t_fixed_r9();
                t_req_r10_r11();
            end
            begin
                repeat (5000) @(posedge clk);
                n_vec++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule